// File: doc/BRIEF.md
# SDRAM Rank Window Decoder

This block maps a 36-bit CPU physical address onto one of several DRAM ranks. Each rank owns a programmable window, described by a base word and a size word. The decoder compares the incoming address against every enabled window in parallel. It reports which rank was picked as a one-hot select and gives the attribute code that rank carries. It also returns the address offset inside the rank.

Windows are placed and sized in 16 MB pages. The base word carries page bits 31:24 of the address and four extra bits for address lines 35:32. The size word carries the window length minus one, counted in pages, along with an enable bit and a small chip-select field that is stored for software. The attribute of a rank is a one-cold nibble in which the bit for that rank is cleared. An external coherency request can add a flag above the nibble. The DRAM target identifier is reported as zero.

Register writes go through a simple single-cycle write port with a combinational read port. The address decode itself is purely combinational from the stored registers and the CPU address.

Top module: `dram_rank_decode`

## Requirements
- R1: After reset every register reads zero, every window is disabled, and the decode reports a miss.
- R2: Register byte offset n*8 holds the base word of window n and n*8+4 holds its size word. Base reads keep only bits 31:24 and 3:0, and size reads keep only bits 31:24, 4:2 and 0, with all other bits zero. A write or read whose offset has bits 1:0 non-zero is ignored and reads zero.
- R3: A register write is visible on the read port and in the decode from the cycle after the write edge, and not before. Without a write, the stored registers do not change.
- R4: Window n hits when its size bit 0 is set and address bits 35:24, with the bits set in size[31:24] masked out, equal {base[3:0], base[31:24]} masked the same way.
- R5: When several windows hit, the lowest-numbered one wins. The select output is one-hot on that window index, and the hit flag is high exactly when a bit of the select is high.
- R6: On a hit of window n, attribute bits 3:0 equal 4'hF with bit n cleared (window 0 gives 0xE, window 3 gives 0x7).
- R7: On a hit, attribute bit 4 equals the coherency-enable input.
- R8: On a hit, the offset equals the address with the window's fixed page bits cleared, so bits 23:0 pass through and bits 35:24 keep only the bits inside the size mask.
- R9: On a miss, including an address that falls only in disabled windows, the hit flag, select, attribute and offset are all zero.
- R10: The DRAM target identifier output is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at reg_addr |
| cpu_addr | input | 36 | Physical address to decode |
| coh_en | input | 1 | Coherency request, sets attribute bit 4 on a hit |
| rank_hit | output | 1 | A window matched |
| rank_sel | output | 4 | One-hot selected rank |
| rank_attr | output | 5 | Attribute of the selected rank |
| rank_offset | output | 36 | Address offset within the rank |
| target_id | output | 4 | DRAM target identifier, constant zero |

## Verification
A corrupted stored base or size word shows on the read port at that offset as soon as it is addressed. It also shows in the decode of any address that lands in or near the window, in the same cycle the address is applied. A broken priority or attribute encoding shows up immediately on overlapping windows, because the select and attribute outputs disagree with the lowest-index rule. Decode faults have no latency, since the whole path is combinational. Write faults appear one cycle after the write edge, so the bench samples both before and after that edge.

// File: rtl/dram_rank_pkg.sv
package dram_rank_pkg;
    localparam int REG_W      = 32;
    localparam int PAGE_SHIFT = 24;
    localparam int HI_W       = 4;
    localparam int SPAN_W     = REG_W - PAGE_SHIFT;
    localparam int PAGE_W     = SPAN_W + HI_W;
    localparam int PHYS_W     = REG_W + HI_W;

    localparam logic [REG_W-1:0] BASE_KEEP = 32'hFF00_000F;
    localparam logic [REG_W-1:0] SIZE_KEEP = 32'hFF00_001D;

    typedef struct packed {
        logic              en;
        logic [PAGE_W-1:0] page;
        logic [SPAN_W-1:0] span;
    } win_match_t;
endpackage

// File: rtl/dram_rank_regs.sv
module dram_rank_regs
    import dram_rank_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int IDX_W   = 2,
    parameter int RA_W    = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [RA_W-1:0]              addr,
    input  logic [REG_W-1:0]             wdata,
    output logic [REG_W-1:0]             rdata,
    output win_match_t [NUM_WIN-1:0]     win
);
    typedef struct packed {
        logic [NUM_WIN-1:0][REG_W-1:0] base;
        logic [NUM_WIN-1:0][REG_W-1:0] size;
    } regs_t;

    regs_t regs_d, regs_q;

    logic             aligned;
    logic             sel_size;
    logic [IDX_W-1:0] idx;
    logic             idx_ok;

    assign aligned  = (addr[1:0] == 2'b00);
    assign sel_size = addr[2];
    assign idx      = addr[RA_W-1:3];
    assign idx_ok   = (32'(idx) < NUM_WIN);

    always_comb begin
        regs_d = regs_q;
        if (wr_en && aligned && idx_ok) begin
            if (sel_size) regs_d.size[idx] = wdata & SIZE_KEEP;
            else          regs_d.base[idx] = wdata & BASE_KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        if (aligned && idx_ok)
            rdata = sel_size ? regs_q.size[idx] : regs_q.base[idx];
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        assign win[g].en   = regs_q.size[g][0];
        assign win[g].page = {regs_q.base[g][HI_W-1:0], regs_q.base[g][REG_W-1:PAGE_SHIFT]};
        assign win[g].span = regs_q.size[g][REG_W-1:PAGE_SHIFT];

        // R3: a base write lands in the next cycle
        p_base_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == RA_W'(g * 8)) |=> regs_q.base[g] == $past(wdata & BASE_KEEP));
        // R3: a size write lands in the next cycle
        p_size_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == RA_W'(g * 8 + 4)) |=> regs_q.size[g] == $past(wdata & SIZE_KEEP));
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));
    p_unaligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !aligned) |=> $stable(regs_q));
endmodule

// File: rtl/dram_rank_match.sv
module dram_rank_match
    import dram_rank_pkg::*;
(
    input  win_match_t        win,
    input  logic [PHYS_W-1:0] addr,
    output logic              hit,
    output logic [PHYS_W-1:0] offset
);
    logic [PAGE_W-1:0] fixed_bits;
    logic [PAGE_W-1:0] addr_page;

    assign addr_page  = addr[PHYS_W-1:PAGE_SHIFT];
    assign fixed_bits = ~{{(PAGE_W-SPAN_W){1'b0}}, win.span};

    always_comb begin
        hit    = win.en && ((addr_page & fixed_bits) == (win.page & fixed_bits));
        offset = {addr_page & ~fixed_bits, addr[PAGE_SHIFT-1:0]};
    end
endmodule

// File: rtl/dram_rank_pick.sv
module dram_rank_pick #(
    parameter int NUM_WIN = 4,
    parameter int IDX_W   = 2,
    parameter int PHYS_W  = 36
) (
    input  logic [NUM_WIN-1:0]             hits,
    input  logic [NUM_WIN-1:0][PHYS_W-1:0] offs,
    output logic [NUM_WIN-1:0]             sel,
    output logic [IDX_W-1:0]               idx,
    output logic                           any,
    output logic [PHYS_W-1:0]              off
);
    always_comb begin
        sel = '0;
        idx = '0;
        any = 1'b0;
        off = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                sel    = '0;
                sel[i] = 1'b1;
                idx    = IDX_W'(i);
                any    = 1'b1;
                off    = offs[i];
            end
        end
    end
endmodule

// File: rtl/dram_rank_decode.sv
module dram_rank_decode
    import dram_rank_pkg::*;
#(
    parameter  int NUM_WIN = 4,
    localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int RA_W    = IDX_W + 3,
    localparam int ATTR_W  = NUM_WIN + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [PHYS_W-1:0] cpu_addr,
    input  logic              coh_en,
    output logic              rank_hit,
    output logic [NUM_WIN-1:0] rank_sel,
    output logic [ATTR_W-1:0] rank_attr,
    output logic [PHYS_W-1:0] rank_offset,
    output logic [3:0]        target_id
);
    win_match_t [NUM_WIN-1:0]         win;
    logic [NUM_WIN-1:0]               hits;
    logic [NUM_WIN-1:0][PHYS_W-1:0]   offs;
    logic [IDX_W-1:0]                 pick_idx;

    dram_rank_regs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .RA_W(RA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .win   (win)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
        dram_rank_match u_match (
            .win    (win[g]),
            .addr   (cpu_addr),
            .hit    (hits[g]),
            .offset (offs[g])
        );

        // R9: a disabled window never matches
        p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !win[g].en |-> !hits[g]);
    end

    dram_rank_pick #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .PHYS_W(PHYS_W)) u_pick (
        .hits (hits),
        .offs (offs),
        .sel  (rank_sel),
        .idx  (pick_idx),
        .any  (rank_hit),
        .off  (rank_offset)
    );

    always_comb begin
        rank_attr = '0;
        if (rank_hit) begin
            rank_attr[NUM_WIN-1:0] = ~(NUM_WIN'(1) << pick_idx);
            rank_attr[NUM_WIN]     = coh_en;
        end
    end

    assign target_id = 4'h0;

    p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rank_sel));
    p_hit_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rank_hit == (rank_sel != '0));
    p_attr_onecold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rank_hit |-> (((rank_attr[NUM_WIN-1:0] | rank_sel) == '1) &&
                      ((rank_attr[NUM_WIN-1:0] & rank_sel) == '0)));
    p_coh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rank_hit |-> rank_attr[NUM_WIN] == coh_en);
    p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rank_hit |-> rank_offset[PAGE_SHIFT-1:0] == cpu_addr[PAGE_SHIFT-1:0]);
    p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rank_hit |-> (rank_attr == '0 && rank_offset == '0));
endmodule

// File: tb/test_dram_rank_decode.sv
module test_dram_rank_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [35:0] cpu_addr = '0;
    logic        coh_en = 1'b0;
    logic        rank_hit;
    logic [3:0]  rank_sel;
    logic [4:0]  rank_attr;
    logic [35:0] rank_offset;
    logic [3:0]  target_id;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] m_base [4];
    logic [31:0] m_size [4];

    always #2 clk = ~clk;

    dram_rank_decode i_dram_rank_decode (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
        .coh_en(coh_en), .rank_hit(rank_hit), .rank_sel(rank_sel),
        .rank_attr(rank_attr), .rank_offset(rank_offset), .target_id(target_id)
    );

    task automatic model_write(input logic [4:0] a, input logic [31:0] d);
        if (a[1:0] == 2'b00) begin
            if (a[2]) m_size[a[4:3]] = d & 32'hFF00_001D;
            else      m_base[a[4:3]] = d & 32'hFF00_000F;
        end
    endtask

    function automatic logic [31:0] model_read(input logic [4:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        return a[2] ? m_size[a[4:3]] : m_base[a[4:3]];
    endfunction

    task automatic expect_dec(input logic [35:0] a, input logic coh,
                              output logic hit, output logic [3:0] sel,
                              output logic [4:0] attr, output logic [35:0] off);
        hit = 0; sel = 0; attr = 0; off = 0;
        for (int n = 0; n < 4; n++) begin
            logic [11:0] fixed_m, page;
            fixed_m = ~{4'h0, m_size[n][31:24]};
            page    = {m_base[n][3:0], m_base[n][31:24]};
            if (!hit && m_size[n][0] && ((a[35:24] & fixed_m) == (page & fixed_m))) begin
                hit  = 1;
                sel  = 4'(1 << n);
                attr = {coh, 4'hF & ~4'(1 << n)};
                off  = {a[35:24] & ~fixed_m, a[23:0]};
            end
        end
    endtask

    task automatic check_dec(input string req);
        logic eh; logic [3:0] es; logic [4:0] ea; logic [35:0] eo;
        expect_dec(cpu_addr, coh_en, eh, es, ea, eo);
        checks++;
        if (rank_hit !== eh || rank_sel !== es || rank_attr !== ea ||
            rank_offset !== eo || target_id !== 4'h0) begin
            failures++;
            $display("FAIL %s addr=%h got hit=%b sel=%b attr=%h off=%h tid=%h exp hit=%b sel=%b attr=%h off=%h tid=0",
                     req, cpu_addr, rank_hit, rank_sel, rank_attr, rank_offset, target_id,
                     eh, es, ea, eo);
        end
    endtask

    task automatic decode_at(input logic [35:0] a, input logic coh, input string req);
        @(negedge clk);
        cpu_addr = a;
        coh_en   = coh;
        #1 check_dec(req);
    endtask

    task automatic check_read(input logic [4:0] a, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== model_read(a)) begin
            failures++;
            $display("FAIL %s read @%h got %h exp %h", req, a, reg_rdata, model_read(a));
        end
    endtask

    task automatic write_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0;
        model_write(a, d);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int n = 0; n < 4; n++) begin m_base[n] = 0; m_size[n] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state, R10 target id
        for (int r = 0; r < 8; r++) check_read(5'(r * 4), "R1");
        decode_at(36'h0_00_000000, 0, "R1");
        decode_at(36'h3_45_678901, 1, "R1 R10");

        // R2: read masks on window 3, then disable it
        write_reg(5'h18, 32'hFFFF_FFFF);
        write_reg(5'h1C, 32'hFFFF_FFFF);
        check_read(5'h18, "R2");
        check_read(5'h1C, "R2");
        write_reg(5'h1C, 32'h0);
        write_reg(5'h18, 32'h0);
        // R2: unaligned access ignored and reads zero
        write_reg(5'h01, 32'hFFFF_FFFF);
        write_reg(5'h06, 32'hFFFF_FFFF);
        check_read(5'h00, "R2");
        check_read(5'h04, "R2");
        check_read(5'h01, "R2");

        // R4 R6 R8: window 0 at page 0x10, 16 pages
        write_reg(5'h00, 32'h1000_0000);
        write_reg(5'h04, 32'h0F00_0001);
        decode_at(36'h0_15_123456, 0, "R4 R6 R8");
        decode_at(36'h0_20_000000, 0, "R9");
        // R5: window 1 overlaps window 0
        write_reg(5'h08, 32'h1400_0000);
        write_reg(5'h0C, 32'h0000_0001);
        decode_at(36'h0_14_000100, 0, "R5");
        write_reg(5'h04, 32'h0F00_0000);
        decode_at(36'h0_14_000100, 0, "R5 R9");
        decode_at(36'h0_15_000100, 0, "R9");
        // R4: high address bits, window 2
        write_reg(5'h10, 32'h4000_0003);
        write_reg(5'h14, 32'h0100_0009);
        decode_at(36'h3_41_FFFFFF, 0, "R4 R6 R8");
        decode_at(36'h0_41_FFFFFF, 0, "R4");
        // R7: coherency flag
        decode_at(36'h3_40_000001, 1, "R7");
        decode_at(36'h5_40_000001, 1, "R7 R9");

        // R3: write visible only after the edge
        write_reg(5'h18, 32'hA000_0000);
        write_reg(5'h1C, 32'h0000_0009);
        @(negedge clk);
        cpu_addr = 36'h0_B0_000010; coh_en = 0;
        reg_wr_en = 1; reg_addr = 5'h18; reg_wdata = 32'hB000_0000;
        #1 check_dec("R3");
        checks++;
        if (reg_rdata !== 32'hA000_0000) begin
            failures++;
            $display("FAIL R3 early read got %h exp %h", reg_rdata, 32'hA000_0000);
        end
        @(negedge clk);
        reg_wr_en = 0;
        model_write(5'h18, 32'hB000_0000);
        #1 check_dec("R3");
        check_read(5'h18, "R3");
        check_read(5'h1C, "R2 R3");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            logic [4:0]  a;
            logic [35:0] ad;
            int          w;
            if (($urandom % 3) == 0) begin
                a = {2'($urandom % 4), 1'($urandom % 2), 2'b00};
                write_reg(a, $urandom);
                check_read(a, "R2 R3");
            end
            w = $urandom % 4;
            ad = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
            if (($urandom % 2) == 0)
                ad[35:24] = {m_base[w][3:0], m_base[w][31:24]} ^
                            (12'($urandom) & {4'h0, m_size[w][31:24]});
            decode_at(ad, 1'($urandom % 2), "R4 R5 R6 R7 R8 R9 R10");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule